// File: doc/BRIEF.md
# Registered Dual-Bank Bus Exchanger

This block is a clocked crossing point between one processor-side data port and two memory-side banks: an even bank and an odd bank. Every port of the block is bidirectional at the board level. Here each one is split into an input bus, an output bus and an output-enable flag, so that a pad ring or a bus fabric outside the block can build the real three-state driver.

Going outward, two capture registers sample the processor port. One of them drives the even bank and the other drives the odd bank. Going inward, two more capture registers sample the even and odd bank inputs. A bank-pick input, taken at the clock edge, decides which of the two drives the processor port. Each of the four capture registers has its own active-low load strobe. The drive enables for the processor side and for the bank side are active low and registered, so a change on them takes effect only at the next rising edge.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four capture registers and the pick flop clear to zero and all three output-enable flags go low. After that edge every output data bus reads zero and no port drives.
- R2: At a rising edge where `ld_to_even_n` is 0, `even_out` takes the value that `proc_in` had at that edge.
- R3: At a rising edge where `ld_to_odd_n` is 0, `odd_out` takes the value that `proc_in` had at that edge.
- R4: At a rising edge where a capture register's load strobe is 1, that register keeps its previous contents.
- R5: At a rising edge, the inward even register loads `even_in` when `ld_from_even_n` is 0, and the inward odd register loads `odd_in` when `ld_from_odd_n` is 0.
- R6: After a rising edge where `pick_even` was 1, `proc_out` shows the inward even register. After a rising edge where `pick_even` was 0, it shows the inward odd register.
- R7: `proc_oe` equals the inverse of `proc_drv_n` as sampled at the most recent rising edge.
- R8: `even_oe` and `odd_oe` both equal the inverse of `bank_drv_n` as sampled at the most recent rising edge.
- R9: A change on `pick_even` between rising edges leaves `proc_out` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_in | input | DATA_W | Processor-side data arriving at the block |
| proc_out | output | DATA_W | Processor-side data leaving the block |
| proc_oe | output | 1 | Processor-side drive enable, active high |
| even_in | input | DATA_W | Even-bank data arriving at the block |
| even_out | output | DATA_W | Even-bank data leaving the block |
| even_oe | output | 1 | Even-bank drive enable, active high |
| odd_in | input | DATA_W | Odd-bank data arriving at the block |
| odd_out | output | DATA_W | Odd-bank data leaving the block |
| odd_oe | output | 1 | Odd-bank drive enable, active high |
| ld_to_even_n | input | 1 | Load strobe of the processor-to-even register, active low |
| ld_to_odd_n | input | 1 | Load strobe of the processor-to-odd register, active low |
| ld_from_even_n | input | 1 | Load strobe of the even-to-processor register, active low |
| ld_from_odd_n | input | 1 | Load strobe of the odd-to-processor register, active low |
| pick_even | input | 1 | Inward source pick: 1 selects the even bank, 0 selects the odd bank |
| proc_drv_n | input | 1 | Registered processor-side drive request, active low |
| bank_drv_n | input | 1 | Registered bank-side drive request, active low, shared by both banks |

## Verification
The assertions assume that every input is a known 0 or 1 and is settled at each rising edge, and that reset is held low for at least one edge before the first check that looks back in time. The stimulus meets these assumptions by changing inputs only on the falling edge. The one exception is the deliberate mid-cycle change of the bank pick, which the bench makes between a falling edge and the following rising edge so that it cannot coincide with sampling. Output data is compared only while the matching enable is high, and after reset, when every register is known to hold zero.

// File: rtl/bx_pkg.sv
`timescale 1ns/1ps
package bx_pkg;
  typedef enum logic [1:0] {
    PATH_TO_EVEN   = 2'd0,
    PATH_TO_ODD    = 2'd1,
    PATH_FROM_EVEN = 2'd2,
    PATH_FROM_ODD  = 2'd3
  } path_e;

  localparam int NUM_PATHS = 4;

  function automatic logic load_active(input logic ld_n);
    return ~ld_n;
  endfunction

  function automatic logic drive_active(input logic drv_n);
    return ~drv_n;
  endfunction
endpackage

// File: rtl/bx_capture_reg.sv
`timescale 1ns/1ps
module bx_capture_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  import bx_pkg::*;

  logic load_now;
  assign load_now = load_active(ld_n);

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (load_now) q <= d;
  end

  AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> q == $past(d)); // R2 R3 R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(q)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> q == '0); // R1
endmodule

// File: rtl/bx_return_sel.sv
`timescale 1ns/1ps
module bx_return_sel #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_even,
  input  logic [DATA_W-1:0] even_q,
  input  logic [DATA_W-1:0] odd_q,
  output logic [DATA_W-1:0] sel_data,
  output logic              pick_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pick_q <= 1'b0;
    else        pick_q <= pick_even;
  end

  always_comb begin
    sel_data = pick_q ? even_q : odd_q;
  end

  AST_PICK_EVEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pick_even |=> pick_q); // R6
  AST_PICK_ODD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_even |=> !pick_q); // R6
  AST_PICK_RESET: assert property (@(posedge clk)
    !rst_n |=> !pick_q); // R1
endmodule

// File: rtl/bx_drive_ctl.sv
`timescale 1ns/1ps
module bx_drive_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic proc_drv_n,
  input  logic bank_drv_n,
  output logic proc_oe_q,
  output logic bank_oe_q
);
  import bx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proc_oe_q <= 1'b0;
      bank_oe_q <= 1'b0;
    end else begin
      proc_oe_q <= drive_active(proc_drv_n);
      bank_oe_q <= drive_active(bank_drv_n);
    end
  end

  AST_PROC_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_drv_n |=> proc_oe_q); // R7
  AST_PROC_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    proc_drv_n |=> !proc_oe_q); // R7
  AST_BANK_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_drv_n |=> bank_oe_q); // R8
  AST_BANK_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bank_drv_n |=> !bank_oe_q); // R8
endmodule

// File: rtl/bus_exchanger.sv
`timescale 1ns/1ps
module bus_exchanger #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] proc_in,
  output logic [DATA_W-1:0] proc_out,
  output logic              proc_oe,
  input  logic [DATA_W-1:0] even_in,
  output logic [DATA_W-1:0] even_out,
  output logic              even_oe,
  input  logic [DATA_W-1:0] odd_in,
  output logic [DATA_W-1:0] odd_out,
  output logic              odd_oe,
  input  logic              ld_to_even_n,
  input  logic              ld_to_odd_n,
  input  logic              ld_from_even_n,
  input  logic              ld_from_odd_n,
  input  logic              pick_even,
  input  logic              proc_drv_n,
  input  logic              bank_drv_n
);
  import bx_pkg::*;

  logic [NUM_PATHS-1:0] ld_vec_n;
  logic [DATA_W-1:0]    path_d [NUM_PATHS];
  logic [DATA_W-1:0]    path_q [NUM_PATHS];
  logic                 pick_q;
  logic                 proc_oe_q;
  logic                 bank_oe_q;
  logic [DATA_W-1:0]    inward_data;

  // Map each path to its strobe and source bus
  always_comb begin
    ld_vec_n[PATH_TO_EVEN]   = ld_to_even_n;
    ld_vec_n[PATH_TO_ODD]    = ld_to_odd_n;
    ld_vec_n[PATH_FROM_EVEN] = ld_from_even_n;
    ld_vec_n[PATH_FROM_ODD]  = ld_from_odd_n;
    path_d[PATH_TO_EVEN]     = proc_in;
    path_d[PATH_TO_ODD]      = proc_in;
    path_d[PATH_FROM_EVEN]   = even_in;
    path_d[PATH_FROM_ODD]    = odd_in;
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    bx_capture_reg #(.DATA_W(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_n  (ld_vec_n[p]),
      .d     (path_d[p]),
      .q     (path_q[p])
    );
  end

  bx_return_sel #(.DATA_W(DATA_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_even (pick_even),
    .even_q    (path_q[PATH_FROM_EVEN]),
    .odd_q     (path_q[PATH_FROM_ODD]),
    .sel_data  (inward_data),
    .pick_q    (pick_q)
  );

  bx_drive_ctl u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_drv_n (proc_drv_n),
    .bank_drv_n (bank_drv_n),
    .proc_oe_q  (proc_oe_q),
    .bank_oe_q  (bank_oe_q)
  );

  assign proc_out = inward_data;
  assign proc_oe  = proc_oe_q;
  assign even_out = path_q[PATH_TO_EVEN];
  assign odd_out  = path_q[PATH_TO_ODD];
  assign even_oe  = bank_oe_q;
  assign odd_oe   = bank_oe_q;

  AST_RESET_NO_DRIVE: assert property (@(posedge clk)
    !rst_n |=> (!proc_oe && !even_oe && !odd_oe)); // R1
  AST_EVEN_TO_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_even && !ld_from_even_n) |=> proc_out == $past(even_in)); // R6
  AST_ODD_TO_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    (!pick_even && !ld_from_odd_n) |=> proc_out == $past(odd_in)); // R6
  AST_PROC_TO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_to_even_n |=> even_out == $past(proc_in)); // R2
  AST_PROC_TO_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_to_odd_n |=> odd_out == $past(proc_in)); // R3
  AST_BANKS_SHARE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_drv_n |=> (!even_oe && !odd_oe)); // R8
endmodule

// File: tb/bus_exchanger_tb_top.sv
`timescale 1ns/1ps
module bus_exchanger_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] proc_in, even_in, odd_in;
  logic [W-1:0] proc_out, even_out, odd_out;
  logic         proc_oe, even_oe, odd_oe;
  logic         ld_to_even_n, ld_to_odd_n, ld_from_even_n, ld_from_odd_n;
  logic         pick_even, proc_drv_n, bank_drv_n;

  bus_exchanger #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .proc_in(proc_in), .proc_out(proc_out), .proc_oe(proc_oe),
    .even_in(even_in), .even_out(even_out), .even_oe(even_oe),
    .odd_in(odd_in), .odd_out(odd_out), .odd_oe(odd_oe),
    .ld_to_even_n(ld_to_even_n), .ld_to_odd_n(ld_to_odd_n),
    .ld_from_even_n(ld_from_even_n), .ld_from_odd_n(ld_from_odd_n),
    .pick_even(pick_even), .proc_drv_n(proc_drv_n), .bank_drv_n(bank_drv_n)
  );

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [W-1:0] m_to_even, m_to_odd, m_from_even, m_from_odd;
  logic         m_pick, m_proc_oe, m_bank_oe;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R7 proc_oe", W'(proc_oe), W'(m_proc_oe));
    chk("R8 even_oe", W'(even_oe), W'(m_bank_oe));
    chk("R8 odd_oe", W'(odd_oe), W'(m_bank_oe));
    if (m_bank_oe) begin
      chk("R2 R4 even_out", even_out, m_to_even);
      chk("R3 R4 odd_out", odd_out, m_to_odd);
    end
    if (m_proc_oe)
      chk("R5 R6 proc_out", proc_out, m_pick ? m_from_even : m_from_odd);
  endtask

  // One rising edge: model samples the settled inputs, outputs checked 1 ns later
  task automatic cycle();
    @(posedge clk);
    if (!rst_n) begin
      m_to_even = '0; m_to_odd = '0; m_from_even = '0; m_from_odd = '0;
      m_pick = 1'b0; m_proc_oe = 1'b0; m_bank_oe = 1'b0;
    end else begin
      if (!ld_to_even_n)   m_to_even   = proc_in;
      if (!ld_to_odd_n)    m_to_odd    = proc_in;
      if (!ld_from_even_n) m_from_even = even_in;
      if (!ld_from_odd_n)  m_from_odd  = odd_in;
      m_pick    = pick_even;
      m_proc_oe = ~proc_drv_n;
      m_bank_oe = ~bank_drv_n;
    end
    #1;
    compare_all();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] pattern(input int idx, input int salt);
    return W'((idx * 37 + salt * 113) ^ (idx << 5) ^ (salt * 7));
  endfunction

  task automatic check_reset_state();
    chk("R1 proc_oe", W'(proc_oe), '0);
    chk("R1 even_oe", W'(even_oe), '0);
    chk("R1 odd_oe", W'(odd_oe), '0);
    chk("R1 proc_out", proc_out, '0);
    chk("R1 even_out", even_out, '0);
    chk("R1 odd_out", odd_out, '0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    proc_in = '1; even_in = '1; odd_in = '1;
    ld_to_even_n = 1'b0; ld_to_odd_n = 1'b0; ld_from_even_n = 1'b0; ld_from_odd_n = 1'b0;
    pick_even = 1'b1; proc_drv_n = 1'b0; bank_drv_n = 1'b0;
    @(negedge clk);
    cycle();
    cycle();
    check_reset_state(); // R1
    rst_n = 1'b1;

    // Sweep: every strobe, pick and drive combination under several data salts
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 128; c++) begin
        ld_to_even_n   = c[0];
        ld_to_odd_n    = c[1];
        ld_from_even_n = c[2];
        ld_from_odd_n  = c[3];
        pick_even      = c[4];
        proc_drv_n     = c[5];
        bank_drv_n     = c[6];
        proc_in = (s == 0) ? W'(1 << (c % W)) : pattern(c, s);
        even_in = (s == 1) ? ~W'(1 << (c % W)) : pattern(c + 3, s + 1);
        odd_in  = pattern(c + 11, s + 2);
        cycle();
      end
    end

    // R9: pick toggled between edges must not disturb proc_out
    ld_to_even_n = 1'b1; ld_to_odd_n = 1'b1;
    ld_from_even_n = 1'b0; ld_from_odd_n = 1'b0;
    even_in = 12'h5A3; odd_in = 12'h0C6;
    pick_even = 1'b1; proc_drv_n = 1'b0; bank_drv_n = 1'b0;
    cycle();
    ld_from_even_n = 1'b1; ld_from_odd_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      pick_even = ~pick_even;
      #1;
      chk("R9 proc_out before edge", proc_out, m_pick ? 12'h5A3 : 12'h0C6);
      cycle();
      chk("R9 proc_out after edge", proc_out, pick_even ? 12'h5A3 : 12'h0C6);
    end

    // R4: all strobes idle, inputs churn, contents must hold
    for (int k = 0; k < 8; k++) begin
      proc_in = pattern(k, 9); even_in = pattern(k, 10); odd_in = pattern(k, 11);
      cycle();
    end

    // R1: reset in the middle of traffic
    rst_n = 1'b0;
    ld_to_even_n = 1'b0; ld_to_odd_n = 1'b0;
    cycle();
    check_reset_state();
    rst_n = 1'b1;
    cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule